// File: doc/BRIEF.md
# Pin Multiplexing I/O Controller

This block controls a bank of I/O lines, one bit per pin. For each pin it decides who drives the pad. The pin is either the controller's own general-purpose logic, with its own data and direction, or one of two peripheral functions, A and B. The block also holds a pull-up enable for every pin and passes it to the pad.

Software changes each per-pin setting only through a pair of write-only registers. Writing a 1 to a bit of one register sets the matching status bit. Writing a 1 to a bit of the other register clears it. The result can be read at a separate status address.

Peripheral selection acts on the output path only. Every peripheral input always sees the raw pin input. Some pins have no peripheral function; these stay under the controller's ownership for good.

Top module: `pin_mux_ctrl`

## Requirements
- R1: After reset the status registers read as follows:
  - pull-up status (offset 0x0A) is 0, so every pad_pullup_en bit is 1;
  - A/B status (0x0E) is 0;
  - drive status (0x06) is 0;
  - the data register (0x10) is 0;
  - ownership status (0x02) equals OWN_RESET with every bit of a pin lacking a peripheral forced to 1 (default 0xFFFF_FF0F).
- R2: A 1 written to pull-off (0x09) sets the pull-up status bit, which turns the pad pull-up off (pad_pullup_en = 0). A 1 written to pull-on (0x08) clears that bit. Both work whatever the pin's ownership or direction.
- R3: A 1 written to own-set (0x00) sets the ownership bit, giving the pin to the controller. A 1 written to own-clear (0x01) clears it, giving the pin to the selected peripheral.
- R4: For pins without a peripheral function (HAS_PERIPH bit 0, by default pins 16 to 31), writes to 0x00 and 0x01 have no effect and the ownership bit always reads 1.
- R5: A 1 written to select-A (0x0C) clears the A/B status bit, selecting A. A 1 written to select-B (0x0D) sets it, selecting B. Both take effect whatever the pin's ownership.
- R6: A 1 written to drive-set (0x04) sets the drive status bit, and a 1 written to drive-clear (0x05) clears it. A controller-owned pin has pad_oe equal to its drive bit and pad_out equal to its bit of the data register (0x10, read/write).
- R7: A peripheral-owned pin takes pad_out and pad_oe from peripheral A when its A/B bit is 0 and from peripheral B when the bit is 1.
- R8: periph_in always equals pin_in, whatever the ownership and A/B selection.
- R9: The set and clear addresses and unmapped addresses read as 0. Bits written as 0 leave status unchanged. Reads have no side effects.
- R10: A write takes effect at the rising edge where bus_wr is high: the status and pad outputs change just after that edge and not before. bus_rdata is combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Pad input levels |
| periph_in | output | 32 | Pin input fanned out to peripherals |
| per_a_out | input | 32 | Peripheral A output values |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_b_out | input | 32 | Peripheral B output values |
| per_b_oe | input | 32 | Peripheral B output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pullup_en | output | 32 | Pad pull-up enables, 1 = on |

## Verification
Each status register, and the pad outputs that depend on it, is due at the first rising edge after the strobe, so one cycle after a write. A read is due in the same cycle as its address, and periph_in follows pin_in with no delay. The bench drives bus signals at the falling edge and samples at the next falling edge, half a cycle after the edge that commits the write. One test looks at the pull-up output while the strobe is still high, to confirm the change is not visible before the edge.

// File: rtl/pinmux_pkg.sv
// Shared constants for the pin multiplexing controller: bus width and the
// register word map. Assumes one register per word address.
package pinmux_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_OWN_SET   = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_OWN_CLR   = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_OWN_STAT  = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_DRV_SET   = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_DRV_CLR   = 5'h05;
    localparam logic [ADDR_W-1:0] ADR_DRV_STAT  = 5'h06;
    localparam logic [ADDR_W-1:0] ADR_PULL_ON   = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_PULL_OFF  = 5'h09;
    localparam logic [ADDR_W-1:0] ADR_PULL_STAT = 5'h0A;
    localparam logic [ADDR_W-1:0] ADR_SEL_A     = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_SEL_B     = 5'h0D;
    localparam logic [ADDR_W-1:0] ADR_SEL_STAT  = 5'h0E;
    localparam logic [ADDR_W-1:0] ADR_DOUT      = 5'h10;
endpackage

// File: rtl/pinmux_decode.sv
// Write decoder: turns a bus write into per-register set/clear masks.
// Assumes a single-cycle write strobe; masks are zero when no write hits.
module pinmux_decode
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] own_set,
    output logic [NUM_PINS-1:0] own_clr,
    output logic [NUM_PINS-1:0] drv_set,
    output logic [NUM_PINS-1:0] drv_clr,
    output logic [NUM_PINS-1:0] pull_set,
    output logic [NUM_PINS-1:0] pull_clr,
    output logic [NUM_PINS-1:0] sel_set,
    output logic [NUM_PINS-1:0] sel_clr,
    output logic                dout_we
);
    localparam logic [NUM_PINS-1:0] NONE = '0;

    // Route write data to the one mask selected by the address.
    always_comb begin
        own_set  = (wr && addr == ADR_OWN_SET)  ? wdata : NONE;
        own_clr  = (wr && addr == ADR_OWN_CLR)  ? wdata : NONE;
        drv_set  = (wr && addr == ADR_DRV_SET)  ? wdata : NONE;
        drv_clr  = (wr && addr == ADR_DRV_CLR)  ? wdata : NONE;
        pull_set = (wr && addr == ADR_PULL_OFF) ? wdata : NONE;
        pull_clr = (wr && addr == ADR_PULL_ON)  ? wdata : NONE;
        sel_set  = (wr && addr == ADR_SEL_B)    ? wdata : NONE;
        sel_clr  = (wr && addr == ADR_SEL_A)    ? wdata : NONE;
        dout_we  = wr && addr == ADR_DOUT;
    end
endmodule

// File: rtl/setclr_reg.sv
// One status register changed only by set and clear masks. Locked bits hold
// LOCK_VAL forever. Assumes set and clear never arrive in the same cycle.
module setclr_reg #(
    parameter int                WIDTH     = 32,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0,
    parameter logic [WIDTH-1:0]  LOCK_MASK = '0,
    parameter logic [WIDTH-1:0]  LOCK_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] stat
);
    localparam logic [WIDTH-1:0] FREE = ~LOCK_MASK;

    // Apply set then clear to free bits; force locked bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= RESET_VAL;
        else        stat <= (((stat | set_mask) & ~clr_mask) & FREE) | (LOCK_VAL & LOCK_MASK);
    end

    AST_SET_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & $past(set_mask) & FREE) == ($past(set_mask) & FREE))); // R3
    AST_CLR_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & $past(clr_mask) & FREE) == '0)); // R5
    AST_UNWRITTEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((stat ^ $past(stat)) & ~$past(set_mask | clr_mask)) == '0)); // R9
endmodule

// File: rtl/pin_out_mux.sv
// Per-pin output selection: controller data/enable, or peripheral A or B.
// Assumes own=1 means controller ownership and sel=1 means peripheral B.
module pin_out_mux #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] own,
    input  logic [NUM_PINS-1:0] sel,
    input  logic [NUM_PINS-1:0] drv,
    input  logic [NUM_PINS-1:0] dout,
    input  logic [NUM_PINS-1:0] a_out,
    input  logic [NUM_PINS-1:0] a_oe,
    input  logic [NUM_PINS-1:0] b_out,
    input  logic [NUM_PINS-1:0] b_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // Pick this pin's driver source.
        always_comb begin
            if (own[p]) begin
                pad_out[p] = dout[p];
                pad_oe[p]  = drv[p];
            end else if (sel[p]) begin
                pad_out[p] = b_out[p];
                pad_oe[p]  = b_oe[p];
            end else begin
                pad_out[p] = a_out[p];
                pad_oe[p]  = a_oe[p];
            end
        end
    end

    AST_PIO_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ drv) & own) == '0); // R6
    AST_PERIPH_A_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ a_oe) & ~own & ~sel) == '0); // R7
    AST_PERIPH_B_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ b_out) & ~own & sel) == '0); // R7
endmodule

// File: rtl/pin_mux_ctrl.sv
// Top of the pin multiplexing controller: write decode, four set/clear
// status registers, a data register, the read mux and the pin output mux.
// Assumes one bus access per cycle and that OWN_RESET can only clear bits of
// pins that have a peripheral.
module pin_mux_ctrl
    import pinmux_pkg::*;
#(
    parameter int                   NUM_PINS   = 32,
    parameter logic [NUM_PINS-1:0]  HAS_PERIPH = 32'h0000_FFFF,
    parameter logic [NUM_PINS-1:0]  OWN_RESET  = 32'hFFFF_FF0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] periph_in,
    input  logic [NUM_PINS-1:0] per_a_out,
    input  logic [NUM_PINS-1:0] per_a_oe,
    input  logic [NUM_PINS-1:0] per_b_out,
    input  logic [NUM_PINS-1:0] per_b_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pullup_en
);
    localparam logic [NUM_PINS-1:0] GPIO_ONLY = ~HAS_PERIPH;
    localparam logic [NUM_PINS-1:0] OWN_INIT  = OWN_RESET | GPIO_ONLY;

    logic [NUM_PINS-1:0] own_set, own_clr, drv_set, drv_clr;
    logic [NUM_PINS-1:0] pull_set, pull_clr, sel_set, sel_clr;
    logic                dout_we;
    logic [NUM_PINS-1:0] own_stat, drv_stat, pull_stat, sel_stat, dout_q;

    pinmux_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .own_set(own_set), .own_clr(own_clr), .drv_set(drv_set), .drv_clr(drv_clr),
        .pull_set(pull_set), .pull_clr(pull_clr), .sel_set(sel_set), .sel_clr(sel_clr),
        .dout_we(dout_we)
    );

    setclr_reg #(.WIDTH(NUM_PINS), .RESET_VAL(OWN_INIT), .LOCK_MASK(GPIO_ONLY),
                 .LOCK_VAL({NUM_PINS{1'b1}})) u_own (
        .clk(clk), .rst_n(rst_n), .set_mask(own_set), .clr_mask(own_clr), .stat(own_stat));
    setclr_reg #(.WIDTH(NUM_PINS)) u_drv (
        .clk(clk), .rst_n(rst_n), .set_mask(drv_set), .clr_mask(drv_clr), .stat(drv_stat));
    setclr_reg #(.WIDTH(NUM_PINS)) u_pull (
        .clk(clk), .rst_n(rst_n), .set_mask(pull_set), .clr_mask(pull_clr), .stat(pull_stat));
    setclr_reg #(.WIDTH(NUM_PINS)) u_sel (
        .clk(clk), .rst_n(rst_n), .set_mask(sel_set), .clr_mask(sel_clr), .stat(sel_stat));

    // Controller output data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (dout_we) dout_q <= bus_wdata;
    end

    // Side-effect-free read of status and data; everything else reads zero.
    always_comb begin
        case (bus_addr)
            ADR_OWN_STAT:  bus_rdata = own_stat;
            ADR_DRV_STAT:  bus_rdata = drv_stat;
            ADR_PULL_STAT: bus_rdata = pull_stat;
            ADR_SEL_STAT:  bus_rdata = sel_stat;
            ADR_DOUT:      bus_rdata = dout_q;
            default:       bus_rdata = '0;
        endcase
    end

    // Pull-up status bit 1 means off; inputs reach peripherals untouched.
    assign pad_pullup_en = ~pull_stat;
    assign periph_in     = pin_in;

    pin_out_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .clk(clk), .rst_n(rst_n), .own(own_stat), .sel(sel_stat), .drv(drv_stat), .dout(dout_q),
        .a_out(per_a_out), .a_oe(per_a_oe), .b_out(per_b_out), .b_oe(per_b_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    AST_PULL_OFF_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == ADR_PULL_OFF)
        |-> ((pad_pullup_en & $past(bus_wdata)) == '0)); // R2
    AST_GPIO_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~own_stat & GPIO_ONLY) == '0)); // R4
    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_OWN_SET || bus_addr == ADR_DRV_CLR || bus_addr == ADR_PULL_ON
         || bus_addr == ADR_SEL_B) |-> (bus_rdata == '0)); // R9
    AST_INPUT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        periph_in == pin_in); // R8
endmodule

// File: tb/test_pin_mux_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_pin_mux_ctrl;
    import pinmux_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0, periph_in;
    logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
    logic [31:0] pad_out, pad_oe, pad_pullup_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_mux_ctrl i_pin_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .periph_in(periph_in), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
        .per_b_out(per_b_out), .per_b_oe(per_b_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pullup_en(pad_pullup_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Single-cycle write, then settle to the next falling edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(ADR_OWN_STAT, v);  chk("R1 own reset", v, 32'hFFFF_FF0F);
        rd(ADR_DRV_STAT, v);  chk("R1 drive reset", v, 32'h0);
        rd(ADR_PULL_STAT, v); chk("R1 pull reset", v, 32'h0);
        rd(ADR_SEL_STAT, v);  chk("R1 sel reset", v, 32'h0);
        rd(ADR_DOUT, v);      chk("R1 data reset", v, 32'h0);
        chk("R1 pullups on", pad_pullup_en, 32'hFFFF_FFFF);
        chk("R1 pad_oe off", pad_oe, 32'h0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr = ADR_PULL_OFF; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
        #1 chk("R10 not before edge", {31'b0, pad_pullup_en[8]}, 32'h1);
        @(posedge clk);
        #1 chk("R10 after edge", {31'b0, pad_pullup_en[8]}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        wr(ADR_PULL_ON, 32'h0000_0100);
    endtask

    task automatic t_pull;
        logic [31:0] v;
        wr(ADR_PULL_OFF, 32'h0000_00F3);
        rd(ADR_PULL_STAT, v); chk("R2 pull off set", v, 32'h0000_00F3);
        chk("R2 pad pullup", pad_pullup_en, ~32'h0000_00F3);
        wr(ADR_PULL_ON, 32'h0000_0003);
        rd(ADR_PULL_STAT, v); chk("R2 pull on clear", v, 32'h0000_00F0);
        wr(ADR_PULL_OFF, 32'h0);
        rd(ADR_PULL_STAT, v); chk("R9 zero bits keep", v, 32'h0000_00F0);
        rd(ADR_PULL_STAT, v); chk("R9 reread same", v, 32'h0000_00F0);
    endtask

    task automatic t_own;
        logic [31:0] v;
        wr(ADR_OWN_CLR, 32'hFFFF_FFFF);
        rd(ADR_OWN_STAT, v); chk("R4 locked on clear", v, 32'hFFFF_0000);
        wr(ADR_OWN_SET, 32'h0000_00F0);
        rd(ADR_OWN_STAT, v); chk("R3 own set", v, 32'hFFFF_00F0);
        wr(ADR_OWN_CLR, 32'hFFFF_0000);
        rd(ADR_OWN_STAT, v); chk("R4 gpio-only ignored", v, 32'hFFFF_00F0);
        rd(ADR_PULL_STAT, v); chk("R2 pull unaffected by own", v, 32'h0000_00F0);
    endtask

    task automatic t_sel;
        logic [31:0] v;
        wr(ADR_SEL_B, 32'h0000_0F0F);
        rd(ADR_SEL_STAT, v); chk("R5 select B", v, 32'h0000_0F0F);
        wr(ADR_SEL_A, 32'h0000_000F);
        rd(ADR_SEL_STAT, v); chk("R5 select A", v, 32'h0000_0F00);
        wr(ADR_SEL_B, 32'h8000_0000);
        rd(ADR_SEL_STAT, v); chk("R5 any ownership", v, 32'h8000_0F00);
    endtask

    task automatic t_drive;
        logic [31:0] v;
        wr(ADR_OWN_SET, 32'hFFFF_FFFF);
        wr(ADR_DOUT, 32'hA5A5_5A5A);
        wr(ADR_DRV_SET, 32'h0000_FFFF);
        chk("R6 pad_oe from drive", pad_oe, 32'h0000_FFFF);
        chk("R6 pad_out from data", pad_out, 32'hA5A5_5A5A);
        wr(ADR_DRV_CLR, 32'h0000_00FF);
        rd(ADR_DRV_STAT, v); chk("R6 drive clear", v, 32'h0000_FF00);
        chk("R6 pad_oe after clear", pad_oe, 32'h0000_FF00);
        rd(ADR_DOUT, v); chk("R6 data readback", v, 32'hA5A5_5A5A);
    endtask

    task automatic t_periph;
        per_a_out = 32'h1111_1111; per_a_oe = 32'h0000_000F;
        per_b_out = 32'h2222_2222; per_b_oe = 32'h0000_00F0;
        wr(ADR_OWN_CLR, 32'h0000_00FF);
        chk("R7 A out", pad_out, 32'hA5A5_5A11);
        chk("R7 A oe", pad_oe, 32'h0000_FF0F);
        wr(ADR_SEL_B, 32'h0000_00FF);
        chk("R7 B out", pad_out, 32'hA5A5_5A22);
        chk("R7 B oe", pad_oe, 32'h0000_FFF0);
    endtask

    task automatic t_input;
        pin_in = 32'hDEAD_BEEF;
        #1 chk("R8 input pass B", periph_in, 32'hDEAD_BEEF);
        wr(ADR_SEL_A, 32'hFFFF_FFFF);
        pin_in = 32'h1234_5678;
        #1 chk("R8 input pass A", periph_in, 32'h1234_5678);
    endtask

    task automatic t_readzero;
        logic [31:0] v;
        rd(ADR_OWN_SET, v);  chk("R9 set reads zero", v, 32'h0);
        rd(ADR_DRV_CLR, v);  chk("R9 clear reads zero", v, 32'h0);
        rd(ADR_PULL_OFF, v); chk("R9 pull-off reads zero", v, 32'h0);
        rd(5'h1F, v);        chk("R9 unmapped reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_timing;
        t_pull;
        t_own;
        t_sel;
        t_drive;
        t_periph;
        t_input;
        t_readzero;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule